// File: doc/BRIEF.md
# UART Register Front End on APB

This block is the register-facing half of a UART. An APB3 slave with zero wait states decodes a small window of registers for data, status, control, prescaler and FIFO debug. It holds received bytes in a circular receive FIFO. A byte-wide receive input fills the FIFO, and reads of the data register drain it. Writes to the data register hand one byte to a transmit output when the transmitter is enabled. Serial bit timing, baud generation, parity and flow control live elsewhere. This block only presents the byte streams to software.

Status flags report receive occupancy and overrun. The transmit path always reports itself empty. Receive and transmit events raise a single-cycle interrupt pulse, and each event is gated by its own control bit. The bus address is masked to its low byte before decoding, so the window repeats every 256 bytes.

Top module: `uart_apb_front`

## Requirements
- R1: After reset the control register reads 0, the receive FIFO is empty, the status register reads 0x0000_0006 (only bits 1 and 2 set), and irq_o and tx_valid_o are low.
- R2: A byte presented with rx_valid_i while control bit 0 (receive enable) is 1 is stored in the FIFO and sets status bit 0. When control bit 0 is 0, the byte is dropped and leaves the FIFO and status unchanged.
- R3: A read at byte offset 0x00 or 0x03 returns the oldest FIFO byte in bits 7:0 (upper bits zero) and removes it. Status bit 0 clears when the FIFO becomes empty. A read of an empty FIFO returns 0.
- R4: A write at offset 0x00 or 0x03 while control bit 1 (transmit enable) is 1 drives tx_valid_o high for exactly the next cycle, with tx_data_o equal to the written bits 7:0. When control bit 1 is 0, the write has no effect on the transmit output.
- R5: irq_o pulses high for one cycle after a stored received byte when control bit 2 is 1, and after a transmitted byte when control bit 3 is 1. When both happen in the same cycle they give one pulse. Nothing else raises irq_o.
- R6: Status bit 0 is data ready, bits 1 and 2 always read 1, bit 4 is overrun, bit 8 is 1 while the FIFO holds at least half its depth, and bit 10 is 1 while the FIFO is full. All other status bits read 0.
- R7: A received byte that finds the FIFO full, with no pop in the same cycle, is discarded and sets status bit 4. A write to offset 0x04 with bit 4 at 0 clears that bit. Any other effect of a status write is ignored.
- R8: Offset 0x08 reads back the full 32-bit value last written to it. Offsets 0x0C and 0x10 and every other undecoded offset read 0 and ignore writes. Only paddr_i bits 7:0 take part in decoding.
- R9: A pop and a receive in the same cycle both take effect. A full FIFO accepts the new byte without overrun. A read of an empty FIFO returns 0 and the arriving byte is kept.
- R10: pready_o is always 1 and pslverr_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data, valid in the access phase |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error, tied low |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Transmit byte strobe, one cycle |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Interrupt pulse |

## Verification
A received byte can arrive in the same cycle in which a data-register read pops the FIFO. The same cycle can also carry a transmit write, so both interrupt sources fire at once. The bench provokes these cases by asserting the receive strobe during an APB access phase: against a full FIFO, against an empty one, and together with an enabled transmit write. Random traffic also overlaps them freely. A queue model applies the pop before the push and merges the two interrupt causes into one pulse. Every read value, transmit strobe and interrupt cycle is judged against that model.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    localparam logic [7:0] OFS_DATA    = 8'h00;
    localparam logic [7:0] OFS_DATA_B3 = 8'h03;
    localparam logic [7:0] OFS_STATUS  = 8'h04;
    localparam logic [7:0] OFS_CTRL    = 8'h08;
    localparam logic [7:0] OFS_SCALER  = 8'h0C;
    localparam logic [7:0] OFS_DEBUG   = 8'h10;

    // control bit positions
    localparam int CB_RX_EN  = 0;
    localparam int CB_TX_EN  = 1;
    localparam int CB_RX_IRQ = 2;
    localparam int CB_TX_IRQ = 3;

    // status bit positions
    localparam int SB_READY   = 0;
    localparam int SB_TSH_MT  = 1;
    localparam int SB_TFIFO_MT = 2;
    localparam int SB_OVERRUN = 4;
    localparam int SB_RX_HALF = 8;
    localparam int SB_RX_FULL = 10;

    typedef enum logic [2:0] {
        SEL_DATA,
        SEL_STATUS,
        SEL_CTRL,
        SEL_SCALER,
        SEL_DEBUG,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/uart_fe_decode.sv
module uart_fe_decode
    import uart_fe_pkg::*;
(
    input  logic [7:0] ofs_i,
    output reg_sel_e   sel_o
);

    always_comb begin
        unique case (ofs_i)
            OFS_DATA, OFS_DATA_B3: sel_o = SEL_DATA;
            OFS_STATUS:            sel_o = SEL_STATUS;
            OFS_CTRL:              sel_o = SEL_CTRL;
            OFS_SCALER:            sel_o = SEL_SCALER;
            OFS_DEBUG:             sel_o = SEL_DEBUG;
            default:               sel_o = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/uart_fe_rxfifo.sv
module uart_fe_rxfifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CW-1:0]     count_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              accept_o,
    output logic              drop_o
);

    typedef struct packed {
        logic [AW-1:0] rd_ptr;
        logic [AW-1:0] wr_ptr;
        logic [CW-1:0] count;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic pop, push;

    function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty_o  = (s_q.count == '0);
    assign full_o   = (s_q.count == CW'(DEPTH));
    assign pop      = rd_i && !empty_o;
    assign push     = wr_i && (!full_o || pop);
    assign accept_o = push;
    assign drop_o   = wr_i && !push;
    assign head_o   = mem_q[s_q.rd_ptr];
    assign count_o  = s_q.count;

    always_comb begin
        s_d = s_q;
        if (pop) begin
            s_d.rd_ptr = nxt_ptr(s_q.rd_ptr);
        end
        if (push) begin
            s_d.wr_ptr = nxt_ptr(s_q.wr_ptr);
        end
        if (push && !pop) begin
            s_d.count = s_q.count + CW'(1);
        end else if (pop && !push) begin
            s_d.count = s_q.count - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[s_q.wr_ptr] <= wdata_i;
        end
    end

    // R7
    full_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && full_o && !rd_i) |=> (count_o == CW'(DEPTH)));

    // R3
    pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !empty_o && !wr_i) |=> (count_o == $past(count_o) - CW'(1)));

endmodule

// File: rtl/uart_fe_core.sv
module uart_fe_core
    import uart_fe_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          access_i,
    input  logic          pwrite_i,
    input  reg_sel_e      sel_i,
    input  logic [31:0]   pwdata_i,
    output logic [31:0]   prdata_o,
    input  logic          rx_valid_i,
    input  logic [7:0]    fifo_head_i,
    input  logic [CW-1:0] fifo_count_i,
    input  logic          fifo_empty_i,
    input  logic          fifo_full_i,
    input  logic          fifo_accept_i,
    input  logic          fifo_drop_i,
    output logic          fifo_wr_o,
    output logic          fifo_rd_o,
    output logic          tx_valid_o,
    output logic [7:0]    tx_data_o,
    output logic          irq_o
);

    typedef struct packed {
        logic [31:0] ctrl;
        logic        ready;
        logic        overrun;
        logic        tx_valid;
        logic [7:0]  tx_data;
        logic        irq;
    } core_state_t;

    core_state_t s_d, s_q;
    logic wr_acc, rd_acc, tx_evt, last_pop;
    logic [31:0] status;

    assign wr_acc    = access_i && pwrite_i;
    assign rd_acc    = access_i && !pwrite_i;
    assign fifo_wr_o = rx_valid_i && s_q.ctrl[CB_RX_EN];
    assign fifo_rd_o = rd_acc && (sel_i == SEL_DATA);
    assign tx_evt    = wr_acc && (sel_i == SEL_DATA) && s_q.ctrl[CB_TX_EN];
    assign last_pop  = fifo_rd_o && (fifo_empty_i || fifo_count_i == CW'(1));

    always_comb begin
        status              = '0;
        status[SB_READY]    = s_q.ready;
        status[SB_TSH_MT]   = 1'b1;
        status[SB_TFIFO_MT] = 1'b1;
        status[SB_OVERRUN]  = s_q.overrun;
        status[SB_RX_HALF]  = (fifo_count_i >= CW'(HALF));
        status[SB_RX_FULL]  = fifo_full_i;
    end

    always_comb begin
        unique case (sel_i)
            SEL_DATA:   prdata_o = fifo_empty_i ? 32'h0 : {24'h0, fifo_head_i};
            SEL_STATUS: prdata_o = status;
            SEL_CTRL:   prdata_o = s_q.ctrl;
            default:    prdata_o = 32'h0;
        endcase
    end

    always_comb begin
        s_d          = s_q;
        s_d.tx_valid = 1'b0;
        s_d.irq      = 1'b0;
        if (wr_acc && sel_i == SEL_CTRL) begin
            s_d.ctrl = pwdata_i;
        end
        if (tx_evt) begin
            s_d.tx_valid = 1'b1;
            s_d.tx_data  = pwdata_i[7:0];
        end
        if (wr_acc && sel_i == SEL_STATUS && !pwdata_i[SB_OVERRUN]) begin
            s_d.overrun = 1'b0;
        end
        if (fifo_drop_i) begin
            s_d.overrun = 1'b1;
        end
        if (fifo_accept_i) begin
            s_d.ready = 1'b1;
        end else if (last_pop) begin
            s_d.ready = 1'b0;
        end
        s_d.irq = (fifo_accept_i && s_q.ctrl[CB_RX_IRQ]) ||
                  (tx_evt && s_q.ctrl[CB_TX_IRQ]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid_o = s_q.tx_valid;
    assign tx_data_o  = s_q.tx_data;
    assign irq_o      = s_q.irq;

    // R8
    ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access_i && pwrite_i && sel_i == SEL_CTRL) |=> (s_q.ctrl == $past(pwdata_i)));

    // R4
    tx_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access_i && pwrite_i && sel_i == SEL_DATA && s_q.ctrl[CB_TX_EN])
        |=> (tx_valid_o && tx_data_o == $past(pwdata_i[7:0])));

    // R5
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl[CB_RX_IRQ] && !s_q.ctrl[CB_TX_IRQ]) |=> !irq_o);

    // R3
    ready_tracks_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ready == !fifo_empty_i);

    // R7
    overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_drop_i |=> s_q.overrun);

endmodule

// File: rtl/uart_apb_front.sv
module uart_apb_front
    import uart_fe_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [ADDR_W-1:0] paddr_i,
    input  logic [31:0]       pwdata_i,
    output logic [31:0]       prdata_o,
    output logic              pready_o,
    output logic              pslverr_o,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_data_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    output logic              irq_o
);

    reg_sel_e        sel;
    logic            fifo_wr, fifo_rd, fifo_empty, fifo_full, fifo_accept, fifo_drop;
    logic [7:0]      fifo_head;
    logic [CW-1:0]   fifo_count;
    logic            unused_addr_hi;

    assign unused_addr_hi = ^paddr_i[ADDR_W-1:8];
    assign pready_o  = 1'b1;
    assign pslverr_o = 1'b0;

    uart_fe_decode i_decode (
        .ofs_i (paddr_i[7:0]),
        .sel_o (sel)
    );

    uart_fe_rxfifo #(.DEPTH(DEPTH), .DATA_W(8)) i_rxfifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (fifo_wr),
        .wdata_i  (rx_data_i),
        .rd_i     (fifo_rd),
        .head_o   (fifo_head),
        .count_o  (fifo_count),
        .empty_o  (fifo_empty),
        .full_o   (fifo_full),
        .accept_o (fifo_accept),
        .drop_o   (fifo_drop)
    );

    uart_fe_core #(.DEPTH(DEPTH)) i_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .access_i      (psel_i && penable_i),
        .pwrite_i      (pwrite_i),
        .sel_i         (sel),
        .pwdata_i      (pwdata_i),
        .prdata_o      (prdata_o),
        .rx_valid_i    (rx_valid_i),
        .fifo_head_i   (fifo_head),
        .fifo_count_i  (fifo_count),
        .fifo_empty_i  (fifo_empty),
        .fifo_full_i   (fifo_full),
        .fifo_accept_i (fifo_accept),
        .fifo_drop_i   (fifo_drop),
        .fifo_wr_o     (fifo_wr),
        .fifo_rd_o     (fifo_rd),
        .tx_valid_o    (tx_valid_o),
        .tx_data_o     (tx_data_o),
        .irq_o         (irq_o)
    );

endmodule

// File: tb/test_uart_apb_front.sv
`timescale 1ns/1ps
module test_uart_apb_front;

    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        irq;

    int errors = 0;
    int checks = 0;

    logic [7:0]  q[$];
    logic [31:0] m_ctrl = '0;
    bit          m_ovr = 1'b0;

    always #10 clk = ~clk;

    uart_apb_front i_uart_apb_front (
        .clk(clk), .rst_n(rst_n), .psel_i(psel), .penable_i(penable),
        .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
        .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // 0 data, 1 status, 2 control, 3 reads zero
    function automatic int kind(input logic [11:0] ad);
        case (ad[7:0])
            8'h00, 8'h03: return 0;
            8'h04:        return 1;
            8'h08:        return 2;
            default:      return 3;
        endcase
    endfunction

    function automatic logic [31:0] exp_status();
        logic [31:0] s = 32'h6;
        if (q.size() > 0) s[0] = 1'b1;
        if (m_ovr) s[4] = 1'b1;
        if (q.size() >= D/2) s[8] = 1'b1;
        if (q.size() == D) s[10] = 1'b1;
        return s;
    endfunction

    task automatic step(input bit a, input bit w, input logic [11:0] ad,
                        input logic [31:0] wd, input bit rx, input logic [7:0] rb,
                        input string tag);
        logic [31:0] c_old = m_ctrl;
        int          k = kind(ad);
        logic [31:0] exp_rd;
        bit          exp_tx, acc, exp_irq;
        logic [31:0] got;
        acc = 1'b0;
        case (k)
            0: exp_rd = (q.size() > 0) ? {24'h0, q[0]} : 32'h0;
            1: exp_rd = exp_status();
            2: exp_rd = m_ctrl;
            default: exp_rd = 32'h0;
        endcase
        exp_tx = a && w && (k == 0) && c_old[1];
        if (a && !w && k == 0 && q.size() > 0) void'(q.pop_front());
        if (a && w && k == 1 && !wd[4]) m_ovr = 1'b0;
        if (rx && c_old[0]) begin
            if (q.size() < D) begin q.push_back(rb); acc = 1'b1; end
            else m_ovr = 1'b1;
        end
        if (a && w && k == 2) m_ctrl = wd;
        exp_irq = (acc && c_old[2]) || (exp_tx && c_old[3]);

        @(negedge clk);
        psel = a; penable = 1'b0; pwrite = w; paddr = ad; pwdata = wd;
        @(negedge clk);
        penable = a; rx_valid = rx; rx_data = rb;
        #1;
        got = prdata;
        if (a) begin
            chk(pready === 1'b1 && pslverr === 1'b0, {tag, " R10 bus response"},
                {30'h0, pready, pslverr}, 32'h2);
        end
        if (a && !w) chk(got === exp_rd, {tag, " read data"}, got, exp_rd);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; rx_valid = 1'b0;
        chk(tx_valid === exp_tx, {tag, " R4 tx strobe"}, {31'h0, tx_valid}, {31'h0, exp_tx});
        if (exp_tx) chk(tx_data === wd[7:0], {tag, " R4 tx byte"}, {24'h0, tx_data}, {24'h0, wd[7:0]});
        chk(irq === exp_irq, {tag, " R5 irq pulse"}, {31'h0, irq}, {31'h0, exp_irq});
        @(negedge clk);
        chk(irq === 1'b0 && tx_valid === 1'b0, {tag, " R5 single cycle"},
            {30'h0, irq, tx_valid}, 32'h0);
    endtask

    task automatic rd(input logic [11:0] ad, input string tag);
        step(1, 0, ad, 32'h0, 0, 8'h0, tag);
    endtask
    task automatic wr(input logic [11:0] ad, input logic [31:0] wd, input string tag);
        step(1, 1, ad, wd, 0, 8'h0, tag);
    endtask
    task automatic rx_only(input logic [7:0] b, input string tag);
        step(0, 0, 12'h0, 32'h0, 1, b, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(irq === 1'b0 && tx_valid === 1'b0, "R1 outputs idle after reset", {30'h0, irq, tx_valid}, 32'h0);
        rd(12'h004, "R1 status at reset");
        rd(12'h008, "R1 control at reset");
        rd(12'h000, "R1 fifo empty at reset");

        rx_only(8'h11, "R2 rx disabled");
        rd(12'h004, "R2 status after dropped byte");
        rd(12'h000, "R2 nothing stored");

        wr(12'h008, 32'h0000_000F, "R8 control write");
        rx_only(8'hA1, "R2 rx enabled");
        rx_only(8'hB2, "R2 rx enabled");
        rx_only(8'hC3, "R2 rx enabled");
        rd(12'h004, "R6 status ready");
        rd(12'h000, "R3 pop offset 0");
        rd(12'h003, "R3 pop offset 3");
        rd(12'h000, "R3 pop last");
        rd(12'h004, "R3 ready cleared");
        rd(12'h000, "R3 empty read");

        wr(12'h003, 32'hFFFF_FF5A, "R4 tx at offset 3");
        wr(12'h008, 32'h0000_0005, "R8 control tx off");
        wr(12'h000, 32'h0000_0077, "R4 tx disabled");
        wr(12'h008, 32'h0000_0003, "R8 control no irq");
        wr(12'h000, 32'h0000_0042, "R5 tx without irq enable");
        rx_only(8'h01, "R5 rx without irq enable");
        rd(12'h000, "R3 drain");

        for (int i = 0; i < D; i++) begin
            rx_only(8'(8'h30 + i), "R6 fill");
            if (i == D/2 - 2 || i == D/2 - 1 || i == D - 2) rd(12'h004, "R6 occupancy flags");
        end
        rd(12'h004, "R6 full flag");
        rx_only(8'hEE, "R7 overflow byte");
        rd(12'h004, "R7 overrun set");
        wr(12'h004, 32'hFFFF_FFFF, "R7 status write ignored");
        rd(12'h004, "R7 overrun kept");
        step(1, 0, 12'h000, 32'h0, 1, 8'h99, "R9 pop and push when full");
        rd(12'h004, "R9 still full no new overrun");
        wr(12'h004, 32'h0000_0000, "R7 clear overrun");
        rd(12'h004, "R7 overrun cleared");
        for (int i = 0; i < D; i++) rd(12'h000, "R3 drain in order");
        step(1, 0, 12'h003, 32'h0, 1, 8'h5C, "R9 empty read with arrival");
        rd(12'h000, "R9 arrival kept");

        wr(12'h008, 32'h0000_000F, "R8 control all irqs");
        step(1, 1, 12'h000, 32'h0000_0033, 1, 8'h44, "R5 rx and tx same cycle");
        rd(12'h000, "R5 rx byte stored");

        wr(12'h00C, 32'hDEAD_BEEF, "R8 scaler write");
        rd(12'h00C, "R8 scaler reads zero");
        wr(12'h010, 32'h1234_5678, "R8 debug write");
        rd(12'h010, "R8 debug reads zero");
        rd(12'h014, "R8 unknown reads zero");
        rd(12'h108, "R8 address masked");
        wr(12'h008, 32'hA5A5_0F0F, "R8 control pattern");
        rd(12'h008, "R8 control readback");
        rd(12'h304, "R8 masked status");

        for (int n = 0; n < 600; n++) begin
            logic [11:0] adl [8] = '{12'h000, 12'h003, 12'h004, 12'h008,
                                    12'h00C, 12'h010, 12'h014, 12'h104};
            logic [11:0] ad = adl[$urandom_range(0, 7)];
            logic [31:0] wd = $urandom();
            bit a = ($urandom_range(0, 3) != 0);
            bit w = $urandom_range(0, 1) == 1;
            if (kind(ad) == 2) wd[0] = ($urandom_range(0, 4) != 0);
            if (kind(ad) == 1 && $urandom_range(0, 1) == 1) wd[4] = 1'b1;
            step(a, w, ad, wd, ($urandom_range(0, 1) == 1), 8'($urandom()), "R9 random mix");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule